// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock of an I2C master. The length of each clock phase is set by programmable counts in cycles of the controller clock. There are three pairs of high/low counts, one pair for each speed class. A two-bit speed field picks the pair that drives the clock. The high phase also includes a spike-suppression length and a fixed offset of three cycles. This lets software convert a wanted bus period into register values with one simple formula.

The generator also delays every data-line change by a programmable hold count, measured from the SCL falling edge. It marks every SCL rising and falling edge with a one-cycle pulse, so the bit engine beside it knows when to sample and when to shift. Configuration arrives on a plain write strobe. Writes are accepted only while the controller is disabled.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, `scl_out` and `sda_out` are 1 and both edge pulses are 0.
- R2: While the generator runs, each SCL low phase lasts LOW+1 controller cycles, where LOW is the low count of the selected pair.
- R3: Each SCL high phase lasts HIGH+SPIKE+3 controller cycles. HIGH is the high count of the selected pair. SPIKE is the high-speed spike length when the high-speed pair is selected, and the shared spike length otherwise.
- R4: The speed field value decides the pair. Value 0 selects the standard pair. Value 1 selects the fast pair. Value 2 (fast-plus) also selects the fast pair. Value 3 selects the high-speed pair and its own spike length. When parameter `HS_EN` is 0, value 3 falls back to the fast pair and the shared spike length.
- R5: A high or low count of 0 acts as 1. With zero counts and zero spike, the high phase is 4 cycles and the low phase is 2 cycles.
- R6: `scl_fall_pulse` and `scl_rise_pulse` are each high for exactly one cycle: the first cycle in which `scl_out` shows its new level. They are never high together.
- R7: The generator samples `run` only while idle or at the end of a high phase.
  - When idle with `run` and `ctrl_enable` high, SCL falls one cycle after the sampling edge.
  - When `run` is low at the end of a high phase, SCL stays high and no further pulse appears.
- R8: While the generator runs, `sda_out` changes only at one point per SCL fall: max(HOLD,1) cycles after `scl_out` falls. At that point it takes the value `sda_req` held in the cycle before. At every other time during a run, `sda_out` is unchanged.
- R9: While the generator is idle, `sda_out` follows `sda_req` one cycle later.
- R10: A write made while `ctrl_enable` is 1 has no effect on any register.
- R11: The write map, indexed by `wr_addr`, is:

  | `wr_addr` | Register |
  |---|---|
  | 0 | speed field (`wr_data[1:0]`) |
  | 1 | standard high count |
  | 2 | standard low count |
  | 3 | fast high count |
  | 4 | fast low count |
  | 5 | high-speed high count |
  | 6 | high-speed low count |
  | 7 | shared spike length (low SPK_W bits) |
  | 8 | high-speed spike length (low SPK_W bits) |
  | 9 | SDA hold count |

  Every register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_enable | input | 1 | Controller enabled; blocks configuration writes and permits running |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Register index of the write |
| wr_data | input | CNT_W | Write data |
| run | input | 1 | Transfer request from the bit engine |
| sda_req | input | 1 | Data level wanted by the bit engine |
| scl_out | output | 1 | Serial clock level |
| sda_out | output | 1 | Serial data level after the hold delay |
| scl_rise_pulse | output | 1 | One-cycle mark of an SCL rising edge |
| scl_fall_pulse | output | 1 | One-cycle mark of an SCL falling edge |

## Verification
The first falling-edge pulse is due one cycle after the edge that samples `run`. Each later pulse is due exactly one phase length after the previous one: LOW+1 cycles for a rise, and HIGH+SPIKE+3 cycles for a fall.

The driver stamps the cycle at which it raises `run` and queues each expected pulse with its gap. The monitor compares each pulse against the queue using a posedge counter read at negedges, so every gap is exact.

The data-line checks count negedges from the falling pulse until `sda_out` changes, and compare the count with max(HOLD,1). Idle following is checked one cycle after each `sda_req` change.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

   typedef enum logic [1:0] {
      SPD_STD   = 2'd0,
      SPD_FAST  = 2'd1,
      SPD_FPLUS = 2'd2,
      SPD_HIGH  = 2'd3
   } spd_e;

   typedef enum logic [3:0] {
      RA_SPEED   = 4'd0,
      RA_STD_HI  = 4'd1,
      RA_STD_LO  = 4'd2,
      RA_FAST_HI = 4'd3,
      RA_FAST_LO = 4'd4,
      RA_HS_HI   = 4'd5,
      RA_HS_LO   = 4'd6,
      RA_SPK_LS  = 4'd7,
      RA_SPK_HS  = 4'd8,
      RA_HOLD    = 4'd9
   } reg_addr_e;

   localparam int HIGH_OFFSET = 3;
   localparam int NUM_PAIRS   = 3;

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
   import scl_timing_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int SPK_W = 8,
   parameter int PH_W  = 18,
   parameter bit HS_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_enable,
   input  logic             wr_en,
   input  logic [3:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [PH_W-1:0]  hi_len,
   output logic [PH_W-1:0]  lo_len,
   output logic [CNT_W-1:0] hold_cnt
);

   localparam int NREG = 2 * NUM_PAIRS;

   spd_e                         spd_q;
   logic [NREG-1:0][CNT_W-1:0]   cnt_q;
   logic [1:0][SPK_W-1:0]        spk_q;
   logic [CNT_W-1:0]             hold_q;
   logic                         wr_ok;

   assign wr_ok = wr_en && !ctrl_enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spd_q  <= SPD_STD;
         cnt_q  <= '0;
         spk_q  <= '0;
         hold_q <= '0;
      end else if (wr_ok) begin
         case (reg_addr_e'(wr_addr))
            RA_SPEED:   spd_q    <= spd_e'(wr_data[1:0]);
            RA_STD_HI:  cnt_q[0] <= wr_data;
            RA_STD_LO:  cnt_q[1] <= wr_data;
            RA_FAST_HI: cnt_q[2] <= wr_data;
            RA_FAST_LO: cnt_q[3] <= wr_data;
            RA_HS_HI:   cnt_q[4] <= wr_data;
            RA_HS_LO:   cnt_q[5] <= wr_data;
            RA_SPK_LS:  spk_q[0] <= wr_data[SPK_W-1:0];
            RA_SPK_HS:  spk_q[1] <= wr_data[SPK_W-1:0];
            RA_HOLD:    hold_q   <= wr_data;
            default:    ;
         endcase
      end
   end

   // speed-class resolution; high speed is an option of the instance
   logic hs_allowed;
   generate
      if (HS_EN) begin : g_hs
         assign hs_allowed = 1'b1;
      end else begin : g_no_hs
         assign hs_allowed = 1'b0;
      end
   endgenerate

   logic [1:0] pair_idx;
   always_comb begin
      case (spd_q)
         SPD_STD:   pair_idx = 2'd0;
         SPD_HIGH:  pair_idx = hs_allowed ? 2'd2 : 2'd1;
         default:   pair_idx = 2'd1;
      endcase
   end

   logic [CNT_W-1:0] h_raw, l_raw, h_eff, l_eff;
   logic [SPK_W-1:0] spk_sel;

   assign h_raw   = cnt_q[{pair_idx, 1'b0}];
   assign l_raw   = cnt_q[{pair_idx, 1'b1}];
   assign h_eff   = (h_raw == '0) ? CNT_W'(1) : h_raw;
   assign l_eff   = (l_raw == '0) ? CNT_W'(1) : l_raw;
   assign spk_sel = (pair_idx == 2'd2) ? spk_q[1] : spk_q[0];

   assign hi_len   = PH_W'(h_eff) + PH_W'(spk_sel) + PH_W'(HIGH_OFFSET);
   assign lo_len   = PH_W'(l_eff) + PH_W'(1);
   assign hold_cnt = hold_q;

   // R10: nothing moves while the controller is enabled
   p_cfg_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_enable |=> ($stable(cnt_q) && $stable(spk_q) && $stable(hold_q) && $stable(spd_q)));

   // R5: zero counts never shorten a phase below its floor
   p_len_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_len >= PH_W'(HIGH_OFFSET + 1)) && (lo_len >= PH_W'(2)));

endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
   parameter int PH_W = 18
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic [PH_W-1:0] hi_len,
   input  logic [PH_W-1:0] lo_len,
   output logic            busy,
   output logic            scl,
   output logic            rise_p,
   output logic            fall_p
);

   logic            busy_q, scl_q, rise_q, fall_q;
   logic [PH_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         scl_q  <= 1'b1;
         cnt_q  <= '0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         rise_q <= 1'b0;
         fall_q <= 1'b0;
         if (!busy_q) begin
            if (go) begin
               busy_q <= 1'b1;
               scl_q  <= 1'b0;
               cnt_q  <= lo_len - PH_W'(1);
               fall_q <= 1'b1;
            end
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - PH_W'(1);
         end else if (!scl_q) begin
            scl_q  <= 1'b1;
            cnt_q  <= hi_len - PH_W'(1);
            rise_q <= 1'b1;
         end else if (go) begin
            scl_q  <= 1'b0;
            cnt_q  <= lo_len - PH_W'(1);
            fall_q <= 1'b1;
         end else begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy   = busy_q;
   assign scl    = scl_q;
   assign rise_p = rise_q;
   assign fall_p = fall_q;

   // R2 / R3: the level holds while the phase counter is still running
   p_phase_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != '0) |=> $stable(scl_q));

   // R6: pulses coincide with the first cycle of the new level
   p_rise_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rise_q |-> (scl_q && !$past(scl_q)));
   p_fall_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fall_q |-> (!scl_q && $past(scl_q)));
   p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rise_q, fall_q}));

   // R7: an idle generator keeps the clock high
   p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !go) |=> scl_q);

endmodule

// File: rtl/sda_hold_dly.sv
module sda_hold_dly #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic             fall_p,
   input  logic [CNT_W-1:0] hold,
   input  logic             sda_req,
   output logic             sda
);

   logic             sda_q, pend_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_q  <= 1'b1;
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy) begin
         sda_q  <= sda_req;
         pend_q <= 1'b0;
      end else if (fall_p) begin
         if (hold <= CNT_W'(1)) begin
            sda_q  <= sda_req;
            pend_q <= 1'b0;
         end else begin
            pend_q <= 1'b1;
            cnt_q  <= hold - CNT_W'(2);
         end
      end else if (pend_q) begin
         if (cnt_q == '0) begin
            sda_q  <= sda_req;
            pend_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   assign sda = sda_q;

   // R8: outside the single hold expiry the data line is frozen during a run
   p_sda_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !pend_q && !fall_p) |=> $stable(sda_q));

   // R9: when idle the data line tracks the request one cycle later
   p_sda_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> (sda_q == $past(sda_req)));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
   import scl_timing_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int SPK_W = 8,
   parameter bit HS_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_enable,
   input  logic             wr_en,
   input  logic [3:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             run,
   input  logic             sda_req,
   output logic             scl_out,
   output logic             sda_out,
   output logic             scl_rise_pulse,
   output logic             scl_fall_pulse
);

   localparam int PH_W = CNT_W + 2;

   generate
      if (CNT_W < 4) begin : g_bad_cnt
         $error("CNT_W must be at least 4");
      end
      if (SPK_W < 1 || SPK_W > CNT_W) begin : g_bad_spk
         $error("SPK_W must lie between 1 and CNT_W");
      end
   endgenerate

   logic [PH_W-1:0]  hi_len, lo_len;
   logic [CNT_W-1:0] hold_cnt;
   logic             busy, fall_p, rise_p, scl_w, go;

   assign go = run && ctrl_enable;

   scl_cfg_regs #(
      .CNT_W (CNT_W),
      .SPK_W (SPK_W),
      .PH_W  (PH_W),
      .HS_EN (HS_EN)
   ) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_enable (ctrl_enable),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .hi_len      (hi_len),
      .lo_len      (lo_len),
      .hold_cnt    (hold_cnt)
   );

   scl_phase_ctr #(
      .PH_W (PH_W)
   ) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (go),
      .hi_len (hi_len),
      .lo_len (lo_len),
      .busy   (busy),
      .scl    (scl_w),
      .rise_p (rise_p),
      .fall_p (fall_p)
   );

   sda_hold_dly #(
      .CNT_W (CNT_W)
   ) u_sda (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (busy),
      .fall_p  (fall_p),
      .hold    (hold_cnt),
      .sda_req (sda_req),
      .sda     (sda_out)
   );

   assign scl_out        = scl_w;
   assign scl_rise_pulse = rise_p;
   assign scl_fall_pulse = fall_p;

   // R7: a run never starts unless the controller is enabled
   p_start_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !ctrl_enable) |=> !scl_fall_pulse);

endmodule

// File: tb/tb_scl_timing_gen.sv
`timescale 1ns/1ps
module tb_scl_timing_gen;

   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ctrl_enable = 1'b0;
   logic             wr_en = 1'b0;
   logic [3:0]       wr_addr = '0;
   logic [CNT_W-1:0] wr_data = '0;
   logic             run = 1'b0;
   logic             sda_req = 1'b1;
   logic             scl_out, sda_out, scl_rise_pulse, scl_fall_pulse;

   always #2 clk = ~clk;

   scl_timing_gen #(.CNT_W(CNT_W), .SPK_W(8), .HS_EN(1'b1)) dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .ctrl_enable    (ctrl_enable),
      .wr_en          (wr_en),
      .wr_addr        (wr_addr),
      .wr_data        (wr_data),
      .run            (run),
      .sda_req        (sda_req),
      .scl_out        (scl_out),
      .sda_out        (sda_out),
      .scl_rise_pulse (scl_rise_pulse),
      .scl_fall_pulse (scl_fall_pulse)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_fail = 0;
   int last_cyc = 0;
   bit done = 1'b0;

   typedef struct {
      bit    is_rise;
      int    gap;
      string req;
   } ev_t;
   ev_t exp_q[$];

   task automatic check(bit ok, string req, string what, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // monitor: pops expected pulses and compares kind, gap and level
   always @(negedge clk) begin
      if (rst_n && (scl_rise_pulse || scl_fall_pulse)) begin
         check(!(scl_rise_pulse && scl_fall_pulse), "R6", "both pulses", 1, 0);
         if (exp_q.size() == 0) begin
            check(1'b0, "R7", "unexpected pulse count", 1, 0);
         end else begin
            ev_t e;
            e = exp_q.pop_front();
            check(e.is_rise == scl_rise_pulse, e.req, "edge kind", int'(scl_rise_pulse), int'(e.is_rise));
            check((cyc - last_cyc) == e.gap, e.req, "edge gap", cyc - last_cyc, e.gap);
            check(scl_out == scl_rise_pulse, "R6", "level at pulse", int'(scl_out), int'(scl_rise_pulse));
         end
         last_cyc = cyc;
      end
   end

   task automatic wr(int a, int d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 4'(a);
      wr_data = CNT_W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // driver: queue n periods, run them, stop after the n-th rise
   task automatic burst(int lo, int hi, int n, string lbl);
      int seen;
      exp_q.push_back('{1'b0, 1, {"R7 ", lbl}});
      for (int i = 0; i < n; i++) begin
         if (i > 0) exp_q.push_back('{1'b0, hi, {"R3 ", lbl}});
         exp_q.push_back('{1'b1, lo, {"R2 ", lbl}});
      end
      @(negedge clk);
      run = 1'b1;
      last_cyc = cyc;
      seen = 0;
      while (seen < n) begin
         @(negedge clk);
         if (scl_rise_pulse) seen++;
      end
      run = 1'b0;
      repeat (hi + lo + 8) @(negedge clk);
      check(exp_q.size() == 0, "R7", {"pending pulses ", lbl}, exp_q.size(), 0);
      check(scl_out == 1'b1, "R7", {"idle level ", lbl}, int'(scl_out), 1);
   endtask

   // one period while the data line is moved through the hold delay
   task automatic sda_test(int hold, int lo, int hi, int expect_d);
      int f;
      int k;
      logic v;
      ctrl_enable = 1'b0;
      wr(9, hold);
      ctrl_enable = 1'b1;
      exp_q.push_back('{1'b0, 1, "R7 hold"});
      exp_q.push_back('{1'b1, lo, "R2 hold"});
      @(negedge clk);
      run = 1'b1;
      last_cyc = cyc;
      do @(negedge clk); while (!scl_fall_pulse);
      f = cyc;
      v = ~sda_out;
      sda_req = v;
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (sda_out != v && k < 40);
      check((cyc - f) == expect_d, "R8", "hold delay", cyc - f, expect_d);
      do @(negedge clk); while (!scl_rise_pulse);
      run = 1'b0;
      sda_req = ~v;
      @(negedge clk);
      check(sda_out == v, "R8", "frozen in high phase", int'(sda_out), int'(v));
      repeat (hi + 4) @(negedge clk);
      check(sda_out == ~v, "R9", "idle catch-up", int'(sda_out), int'(~v));
      sda_req = v;
      @(negedge clk);
      check(sda_out == v, "R9", "idle follow", int'(sda_out), int'(v));
   endtask

   initial begin
      repeat (5) @(negedge clk);
      // R1: reset state
      check(scl_out == 1'b1, "R1", "scl reset", int'(scl_out), 1);
      check(sda_out == 1'b1, "R1", "sda reset", int'(sda_out), 1);
      check(!scl_rise_pulse && !scl_fall_pulse, "R1", "pulses reset",
            int'({scl_rise_pulse, scl_fall_pulse}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 map: program all three pairs and both spike lengths
      wr(0, 0);
      wr(1, 5); wr(2, 7);
      wr(3, 3); wr(4, 4);
      wr(5, 2); wr(6, 1);
      wr(7, 2); wr(8, 1);
      wr(9, 0);

      // R2 R3 R4 standard: low 8, high 5+2+3
      ctrl_enable = 1'b1;
      burst(8, 10, 2, "R4 standard");

      // R4 fast: low 5, high 3+2+3
      ctrl_enable = 1'b0; wr(0, 1); ctrl_enable = 1'b1;
      burst(5, 8, 2, "R4 fast");

      // R4 fast-plus reuses the fast pair
      ctrl_enable = 1'b0; wr(0, 2); ctrl_enable = 1'b1;
      burst(5, 8, 2, "R4 fastplus");

      // R4 high speed: low 2, high 2+1+3 with its own spike length
      ctrl_enable = 1'b0; wr(0, 3); ctrl_enable = 1'b1;
      burst(2, 6, 3, "R4 highspeed");

      // R10: writes while enabled are dropped (speed and high-speed high count)
      wr(0, 1);
      wr(5, 40);
      burst(2, 6, 2, "R10 locked");

      // R5: zero counts and zero spike act as the minimum
      ctrl_enable = 1'b0;
      wr(0, 1); wr(3, 0); wr(4, 0); wr(7, 0);
      ctrl_enable = 1'b1;
      burst(2, 4, 3, "R5 zero");

      // R8 R9: hold delay on the standard pair, low 11, high 5+2+3
      ctrl_enable = 1'b0;
      wr(0, 0); wr(2, 10); wr(7, 2);
      sda_test(3, 11, 10, 3);
      sda_test(0, 11, 10, 1);
      sda_test(6, 11, 10, 6);

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R7", "queue drained", exp_q.size(), 0);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "R7", "watchdog expired", 1, 0);
      finish_run();
   end

endmodule